// File: doc/BRIEF.md
# Pointing Device Bring-up Sequencer

This block brings a serial pointing device out of power-up and then services its byte traffic. When it is switched on, it raises its two handshake outputs and then waits for the device to signal readiness on an edge-triggered interrupt line. Each rising edge lets it push the next of four fixed command bytes into an external 8-bit shifter. The shifter runs most significant bit first with an idle-high clock. The commands are, in order: turn reporting off, select streaming, go to standby, turn reporting on.

The edge that follows the fourth command moves the block into receive mode. In that mode every rising edge starts one fetch. The block clocks out a dummy 0x00 byte, waits until the device's active-low busy line reads low, and then passes the byte the shifter collected downstream. The byte is presented with a one-cycle valid strobe.

Switching the block off drops both handshake lines and makes it deaf to the device. A resume from power saving is wired to the enable request, and a suspend or standby to the disable request, so every resume replays the whole bring-up. Every rising edge the block acts on counts as one serviced interrupt; edges that arrive while a transfer is still open are discarded.

Top module: `ptr_init_seq`

## Requirements
- R1: After reset every output is low and the block is switched off.
- R2: An enable request while switched off drives both cmd_req and xfer_rdy high and init_done low on the next cycle. An enable request while already on has no effect, and the command order carries on where it was.
- R3: Successive serviced interrupt edges send the command bytes 0xF5, 0xF2, 0xF8 and 0xF4 in that order, one byte per edge. After each byte completes, both cmd_req and xfer_rdy read high.
- R4: tx_valid rises only in the cycle after one in which dev_busy_n was sampled low. While dev_busy_n stays high, no byte is offered.
- R5: Once raised, tx_valid stays high with tx_data unchanged until tx_done is sampled high. It is low in the cycle after that.
- R6: The first serviced edge after the fourth command sends no byte. It sets cmd_req low, keeps xfer_rdy high and raises init_done.
- R7: In receive mode each serviced edge offers the byte 0x00. After tx_done, the block waits for dev_busy_n to read low, then presents rx_data_in on rx_byte.
- R8: rx_valid is high for exactly one cycle per fetched byte.
- R9: A disable request drops cmd_req, xfer_rdy, init_done and tx_valid on the next cycle, and later edges start no transfer. If enable and disable arrive in the same cycle, disable wins.
- R10: An interrupt edge that arrives while a byte is waiting or in flight is discarded and starts no further transfer.
- R11: An enable after a disable restarts the bring-up from the first command, 0xF5.
- R12: An interrupt line held high is one event; only a low-to-high change is serviced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_req | input | 1 | Switch on (also resume) |
| dis_req | input | 1 | Switch off (also suspend or standby) |
| dev_irq | input | 1 | Device interrupt, rising edge serviced |
| dev_busy_n | input | 1 | Device busy, low means a byte may move |
| tx_done | input | 1 | Shifter finished the offered byte |
| rx_data_in | input | 8 | Byte collected by the shifter |
| tx_valid | output | 1 | Byte offered to the shifter |
| tx_data | output | 8 | Offered byte |
| cmd_req | output | 1 | Command-request handshake line |
| xfer_rdy | output | 1 | Transfer-ready handshake line |
| init_done | output | 1 | Bring-up complete, receive mode |
| rx_valid | output | 1 | One-cycle strobe for rx_byte |
| rx_byte | output | 8 | Fetched byte |

## Verification
The bench holds the busy line high for random stretches before each byte. A design that ignores the line would offer a byte early. It fires an interrupt edge in the middle of a command transfer. A sequencer that queued that edge would skip or send an extra command. It also holds the interrupt high across a whole receive fetch, which a level-sensitive design would turn into a second fetch. Finally, it disables halfway through bring-up and enables again, and it sends a second enable while the block is already on. A wrong counter restart shows up as a misordered command byte in both cases.

// File: rtl/ptr_init_pkg.sv
package ptr_init_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_CMD_IDLE,
        ST_CMD_WAIT,
        ST_CMD_SEND,
        ST_RX_IDLE,
        ST_RX_WAIT,
        ST_RX_SEND,
        ST_RX_FETCH
    } seq_state_e;

    // bring-up command bytes, indexed by step number
    function automatic logic [BYTE_W-1:0] bringup_cmd(input int unsigned step);
        case (step)
            0:       bringup_cmd = 8'hF5; // reporting off
            1:       bringup_cmd = 8'hF2; // streaming
            2:       bringup_cmd = 8'hF8; // standby
            3:       bringup_cmd = 8'hF4; // reporting on
            default: bringup_cmd = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/ptr_irq_edge.sv
module ptr_irq_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_i,
    output logic rise_o
);
    logic irq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_i;
    end

    assign rise_o = irq_i & ~irq_q;
endmodule

// File: rtl/ptr_cmd_table.sv
module ptr_cmd_table #(
    parameter int N_CMD = 4,
    parameter int IDX_W = 3
) (
    input  logic [IDX_W-1:0]                 idx_i,
    output logic [ptr_init_pkg::BYTE_W-1:0] byte_o
);
    logic [ptr_init_pkg::BYTE_W-1:0] table_w [N_CMD];

    for (genvar g = 0; g < N_CMD; g++) begin : g_entry
        assign table_w[g] = ptr_init_pkg::bringup_cmd(g);
    end

    always_comb begin
        byte_o = '0;
        for (int i = 0; i < N_CMD; i++) begin
            if (idx_i == IDX_W'(i)) byte_o = table_w[i];
        end
    end
endmodule

// File: rtl/ptr_init_seq.sv
module ptr_init_seq #(
    parameter int N_CMD  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_req,
    input  logic              dis_req,
    input  logic              dev_irq,
    input  logic              dev_busy_n,
    input  logic              tx_done,
    input  logic [DATA_W-1:0] rx_data_in,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    output logic              cmd_req,
    output logic              xfer_rdy,
    output logic              init_done,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_byte
);
    import ptr_init_pkg::*;

    localparam int CNT_W = $clog2(N_CMD + 1);
    localparam logic [DATA_W-1:0] DUMMY = '0;

    typedef struct packed {
        seq_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic              txv;
        logic [DATA_W-1:0] txd;
        logic              creq;
        logic              rdy;
        logic              done;
        logic              rxv;
        logic [DATA_W-1:0] rxb;
    } seq_regs_t;

    seq_regs_t r_q, r_d;
    logic      irq_rise;
    logic [BYTE_W-1:0] cmd_byte;

    ptr_irq_edge i_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .irq_i  (dev_irq),
        .rise_o (irq_rise)
    );

    ptr_cmd_table #(.N_CMD(N_CMD), .IDX_W(CNT_W)) i_table (
        .idx_i  (r_q.cnt),
        .byte_o (cmd_byte)
    );

    always_comb begin
        r_d     = r_q;
        r_d.rxv = 1'b0;
        if (dis_req) begin
            r_d.st   = ST_OFF;
            r_d.txv  = 1'b0;
            r_d.creq = 1'b0;
            r_d.rdy  = 1'b0;
            r_d.done = 1'b0;
        end else begin
            case (r_q.st)
                ST_OFF: begin
                    if (en_req) begin
                        r_d.st   = ST_CMD_IDLE;
                        r_d.cnt  = '0;
                        r_d.creq = 1'b1;
                        r_d.rdy  = 1'b1;
                        r_d.done = 1'b0;
                    end
                end
                ST_CMD_IDLE: begin
                    if (irq_rise) begin
                        if (r_q.cnt < CNT_W'(N_CMD)) begin
                            r_d.st = ST_CMD_WAIT;
                        end else begin
                            r_d.st   = ST_RX_IDLE;
                            r_d.cnt  = '0;
                            r_d.creq = 1'b0;
                            r_d.rdy  = 1'b1;
                            r_d.done = 1'b1;
                        end
                    end
                end
                ST_CMD_WAIT: begin
                    if (!dev_busy_n) begin
                        r_d.st  = ST_CMD_SEND;
                        r_d.txv = 1'b1;
                        r_d.txd = DATA_W'(cmd_byte);
                    end
                end
                ST_CMD_SEND: begin
                    if (tx_done) begin
                        r_d.st   = ST_CMD_IDLE;
                        r_d.txv  = 1'b0;
                        r_d.cnt  = r_q.cnt + 1'b1;
                        r_d.creq = 1'b1;
                        r_d.rdy  = 1'b1;
                    end
                end
                ST_RX_IDLE: begin
                    if (irq_rise) r_d.st = ST_RX_WAIT;
                end
                ST_RX_WAIT: begin
                    if (!dev_busy_n) begin
                        r_d.st  = ST_RX_SEND;
                        r_d.txv = 1'b1;
                        r_d.txd = DUMMY;
                    end
                end
                ST_RX_SEND: begin
                    if (tx_done) begin
                        r_d.st  = ST_RX_FETCH;
                        r_d.txv = 1'b0;
                    end
                end
                ST_RX_FETCH: begin
                    if (!dev_busy_n) begin
                        r_d.st  = ST_RX_IDLE;
                        r_d.rxv = 1'b1;
                        r_d.rxb = rx_data_in;
                    end
                end
                default: r_d.st = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_OFF, cnt: '0, txv: 1'b0, txd: '0, creq: 1'b0,
                     rdy: 1'b0, done: 1'b0, rxv: 1'b0, rxb: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign tx_valid  = r_q.txv;
    assign tx_data   = r_q.txd;
    assign cmd_req   = r_q.creq;
    assign xfer_rdy  = r_q.rdy;
    assign init_done = r_q.done;
    assign rx_valid  = r_q.rxv;
    assign rx_byte   = r_q.rxb;
endmodule

// File: rtl/ptr_init_chk.sv
module ptr_init_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dis_req,
    input logic              dev_busy_n,
    input logic              tx_done,
    input logic              tx_valid,
    input logic [DATA_W-1:0] tx_data,
    input logic              cmd_req,
    input logic              xfer_rdy,
    input logic              init_done,
    input logic              rx_valid
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> !tx_valid && !rx_valid && !cmd_req && !xfer_rdy && !init_done);

    p_cmd_lines_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req |-> xfer_rdy);

    p_busy_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> !$past(dev_busy_n));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_done && !dis_req |=> tx_valid && $stable(tx_data));

    p_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_done |=> !tx_valid);

    p_done_lines_r6: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> !cmd_req && xfer_rdy);

    p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    p_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dis_req |=> !cmd_req && !xfer_rdy && !tx_valid && !init_done);
endmodule

bind ptr_init_seq ptr_init_chk #(.DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_ptr_init_seq.sv
module test_ptr_init_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_req = 1'b0, dis_req = 1'b0, dev_irq = 1'b0;
    logic       dev_busy_n = 1'b1, tx_done = 1'b0;
    logic [7:0] rx_data_in = 8'h00;
    logic       tx_valid, cmd_req, xfer_rdy, init_done, rx_valid;
    logic [7:0] tx_data, rx_byte;
    int         total = 0, bad = 0, cycles = 0;
    bit         ended = 1'b0;

    always #2 clk = ~clk;

    ptr_init_seq i_ptr_init_seq (.*);

    function automatic logic [7:0] exp_cmd(input int n);
        case (n)
            0: return 8'hF5;
            1: return 8'hF2;
            2: return 8'hF8;
            default: return 8'hF4;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=0", cycles);
            finish_run();
        end
    end

    task automatic pulse(ref logic s);
        @(negedge clk) s = 1'b1;
        @(negedge clk) s = 1'b0;
    endtask

    task automatic quiet(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(!tx_valid, tag, tx_valid, 0);
        end
    endtask

    // one byte out: busy held for a random stretch, then random hold before done
    task automatic byte_out(input logic [7:0] exp, input string tag, input bit fire_mid);
        int d = int'($urandom_range(1, 4));
        int h = int'($urandom_range(0, 3));
        quiet(d, "R4 offered while busy");
        dev_busy_n = 1'b0;
        @(negedge clk);
        chk(tx_valid && tx_data == exp, tag, tx_data, exp);
        if (fire_mid) begin
            dev_irq = 1'b1;
            @(negedge clk) dev_irq = 1'b0;
        end
        for (int i = 0; i < h; i++) begin
            @(negedge clk);
            chk(tx_valid && tx_data == exp, "R5 hold", tx_data, exp);
        end
        tx_done = 1'b1;
        dev_busy_n = 1'b1;
        @(negedge clk) tx_done = 1'b0;
        chk(!tx_valid, "R5 drop after done", tx_valid, 0);
    endtask

    task automatic cmd_step(input int n, input bit fire_mid);
        pulse(dev_irq);
        byte_out(exp_cmd(n), "R3 command byte", fire_mid);
        chk(cmd_req && xfer_rdy, "R3 lines high after command", {cmd_req, xfer_rdy}, 3);
    endtask

    task automatic finish_init();
        pulse(dev_irq);
        chk(init_done && !cmd_req && xfer_rdy && !tx_valid, "R6 receive entry",
            {init_done, cmd_req, xfer_rdy, tx_valid}, 4'b1010);
    endtask

    task automatic rx_step(input logic [7:0] val, input bit hold_irq);
        int d = int'($urandom_range(1, 4));
        if (hold_irq) begin
            @(negedge clk) dev_irq = 1'b1;
        end else pulse(dev_irq);
        byte_out(8'h00, "R7 dummy byte", 1'b0);
        for (int i = 0; i < d; i++) begin
            @(negedge clk);
            chk(!rx_valid && !tx_valid, "R7 fetch waits on busy", rx_valid, 0);
        end
        rx_data_in = val;
        dev_busy_n = 1'b0;
        @(negedge clk) dev_busy_n = 1'b1;
        chk(rx_valid && rx_byte == val, "R7 fetched byte", rx_byte, val);
        @(negedge clk);
        chk(!rx_valid, "R8 strobe one cycle", rx_valid, 0);
        if (hold_irq) begin
            dev_busy_n = 1'b0;
            quiet(6, "R12 held line refetched");
            dev_irq = 1'b0;
            dev_busy_n = 1'b1;
        end
    endtask

    task automatic enable_on();
        pulse(en_req);
        chk(cmd_req && xfer_rdy && !init_done, "R2 enable lines",
            {cmd_req, xfer_rdy, init_done}, 3'b110);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(!tx_valid && !rx_valid && !cmd_req && !xfer_rdy && !init_done, "R1 reset state",
            {tx_valid, rx_valid, cmd_req, xfer_rdy, init_done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!cmd_req && !xfer_rdy, "R1 off after reset", {cmd_req, xfer_rdy}, 0);

        // full bring-up with a re-enable and a stray edge mid-transfer
        enable_on();
        cmd_step(0, 1'b1);
        dev_busy_n = 1'b0;
        quiet(6, "R10 stray edge started transfer");
        dev_busy_n = 1'b1;
        pulse(en_req);
        chk(cmd_req && xfer_rdy, "R2 re-enable lines", {cmd_req, xfer_rdy}, 3);
        cmd_step(1, 1'b0);
        cmd_step(2, 1'b0);
        cmd_step(3, 1'b0);
        finish_init();
        rx_step(8'h3C, 1'b0);
        rx_step(8'hA5, 1'b1);
        for (int i = 0; i < 6; i++) rx_step(8'($urandom), 1'b0);

        // disable halfway through bring-up, then resume from the start
        pulse(dis_req);
        chk(!cmd_req && !xfer_rdy && !init_done, "R9 disable lines",
            {cmd_req, xfer_rdy, init_done}, 0);
        enable_on();
        cmd_step(0, 1'b0);
        cmd_step(1, 1'b0);
        pulse(dis_req);
        chk(!cmd_req && !xfer_rdy, "R9 disable mid init", {cmd_req, xfer_rdy}, 0);
        dev_busy_n = 1'b0;
        pulse(dev_irq);
        quiet(6, "R9 edge served while off");
        dev_busy_n = 1'b1;
        enable_on();
        cmd_step(0, 1'b0); // R11 restart from first command

        // simultaneous enable and disable
        @(negedge clk) begin en_req = 1'b1; dis_req = 1'b1; end
        @(negedge clk) begin en_req = 1'b0; dis_req = 1'b0; end
        chk(!cmd_req && !xfer_rdy, "R9 disable wins", {cmd_req, xfer_rdy}, 0);

        // random rounds
        for (int r = 0; r < 3; r++) begin
            enable_on();
            for (int n = 0; n < 4; n++) cmd_step(n, 1'($urandom));
            finish_init();
            for (int k = 0; k < 5; k++) rx_step(8'($urandom), 1'b0);
            pulse(dis_req);
            chk(!init_done && !cmd_req, "R9 round off", {init_done, cmd_req}, 0);
        end
        finish_run();
    end
endmodule